// File: doc/BRIEF.md
# Configurable Output Macrocell Bank

This block holds the per-output cells that sit after the OR plane of a programmable sum-of-products array. Each cell takes the OR result of its output group and, under a two-bit mode code, sends it either through a D flip-flop or straight through to the pin. The same code picks the output polarity, and it also picks whether the signal fed back into the array is the flip-flop state or the level on the pin. All flip-flops share one clock, one synchronous set term and one asynchronous clear term. Every cell has its own enable term for its three-state pin. The pin is modelled as a driven value, an enable, and the value an external source places on it.

A test preload mode writes each flip-flop straight from the external pin value on a clock edge, so a state machine built in the array can start from any state. While preload is active, the cell drivers are released so that the pins can be driven from outside. A power-up clear input sets every flip-flop to 0. The level then seen on each pin follows from the polarity of its cell.

Top module: `omc_bank`

## Requirements
- R1: While `rst_n` is low, every flip-flop holds 0. A registered active-low cell (mode 00) then drives 1 and a registered active-high cell (mode 01) drives 0.
- R2: While `async_clr` is 1, every flip-flop is 0 at once, without waiting for a clock edge. It wins over `sync_set` and over `preload` in the same cycle.
- R3: When `sync_set` is 1 and neither clear nor preload is active, every flip-flop holds 1 after the next rising clock edge.
- R4: With no clear, preload or set active, each flip-flop captures its `sum_term` bit on every rising clock edge.
- R5: Mode code of cell i is `mode_cfg[2i+1:2i]`. Bit 2i+1 = 0 selects the registered path and bit 2i = 1 selects active-high. A registered cell drives its flip-flop state, inverted when bit 2i is 0.
- R6: A combinational cell (bit 2i+1 = 1) drives `sum_term[i]` in the same cycle, inverted when bit 2i is 0.
- R7: `pin_oe[i]` equals `oe_term[i]` when preload is inactive. It is 0 for every cell while `preload` is 1.
- R8: A registered cell feeds its flip-flop state back, taken before the polarity inversion. A combinational cell feeds back the resolved pin level: `pin_out[i]` when `pin_oe[i]` is 1, otherwise `pin_in[i]`.
- R9: When `preload` is 1 and no clear is active, each flip-flop loads `pin_in[i]` on the rising clock edge. This wins over `sync_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global register clock |
| rst_n | input | 1 | Power-up clear, active low, asynchronous |
| sum_term | input | NCELL | OR-plane result for each cell |
| oe_term | input | NCELL | Output enable product term for each cell |
| mode_cfg | input | 2*NCELL | Mode code per cell, {path, polarity} at bits 2i+1:2i |
| sync_set | input | 1 | Global synchronous set term |
| async_clr | input | 1 | Global asynchronous clear term |
| preload | input | 1 | Test preload mode |
| pin_in | input | NCELL | Level placed on each pin by an external source |
| pin_out | output | NCELL | Value each cell drives on its pin |
| pin_oe | output | NCELL | Pin driver enable per cell |
| array_fb | output | NCELL | Feedback to the array per cell |

## Verification
The asynchronous clear and the synchronous set can land in the same cycle, and so can preload and the synchronous set. The bench first sets every flip-flop to 1. It then raises the clear and the set together at a falling edge. The flip-flop state is checked through the registered feedback before the next rising edge, and again after it; both times every bit must read 0. In a separate cycle, preload and set are raised together with a mixed pin pattern. Only that pattern may appear in the flip-flops afterwards, not all ones.

// File: rtl/omc_pkg.sv
package omc_pkg;

   // mode code per cell: {path, polarity}
   typedef enum logic [1:0] {
      OMC_REG_LO  = 2'b00,
      OMC_REG_HI  = 2'b01,
      OMC_COMB_LO = 2'b10,
      OMC_COMB_HI = 2'b11
   } omc_mode_e;

   localparam int OMC_MODE_W = 2;

   function automatic logic omc_is_comb(input logic [OMC_MODE_W-1:0] m);
      return m[1];
   endfunction

   function automatic logic omc_is_high(input logic [OMC_MODE_W-1:0] m);
      return m[0];
   endfunction

endpackage

// File: rtl/omc_reg.sv
module omc_reg (
   input  logic clk,
   input  logic clr,
   input  logic pre_load,
   input  logic pre_val,
   input  logic set,
   input  logic d,
   output logic q
);
   // priority: clear, then preload, then set, then data
   always_ff @(posedge clk or posedge clr) begin
      if (clr)           q <= 1'b0;
      else if (pre_load) q <= pre_val;
      else if (set)      q <= 1'b1;
      else               q <= d;
   end
endmodule

// File: rtl/omc_outsel.sv
module omc_outsel
   import omc_pkg::*;
(
   input  logic [OMC_MODE_W-1:0] mode,
   input  logic                  sum,
   input  logic                  q,
   input  logic                  oe_term,
   input  logic                  preload,
   input  logic                  pin_in,
   output logic                  pin_out,
   output logic                  pin_oe,
   output logic                  fb
);
   logic path_val;
   logic resolved;

   always_comb begin
      path_val = omc_is_comb(mode) ? sum : q;
      pin_out  = omc_is_high(mode) ? path_val : ~path_val;
      pin_oe   = oe_term & ~preload;
      resolved = pin_oe ? pin_out : pin_in;
      fb       = omc_is_comb(mode) ? resolved : q;
   end
endmodule

// File: rtl/omc_bank.sv
module omc_bank
   import omc_pkg::*;
#(
   parameter int NCELL       = 10,
   parameter bit HAS_PRELOAD = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NCELL-1:0]             sum_term,
   input  logic [NCELL-1:0]             oe_term,
   input  logic [OMC_MODE_W*NCELL-1:0]  mode_cfg,
   input  logic                         sync_set,
   input  logic                         async_clr,
   input  logic                         preload,
   input  logic [NCELL-1:0]             pin_in,
   output logic [NCELL-1:0]             pin_out,
   output logic [NCELL-1:0]             pin_oe,
   output logic [NCELL-1:0]             array_fb
);
   localparam int CFG_W = OMC_MODE_W * NCELL;

   if (NCELL < 1 || NCELL > 64) begin : g_bad_ncell
      $error("omc_bank: NCELL must lie in 1..64");
   end
   if (CFG_W != 2 * NCELL) begin : g_bad_cfg
      $error("omc_bank: mode code width mismatch");
   end

   logic clr_any;
   logic pre_g;

   assign clr_any = async_clr | ~rst_n;

   if (HAS_PRELOAD) begin : g_pre
      assign pre_g = preload;
   end else begin : g_nopre
      assign pre_g = 1'b0;
   end

   for (genvar i = 0; i < NCELL; i++) begin : g_cell
      logic q;

      omc_reg u_reg (
         .clk      (clk),
         .clr      (clr_any),
         .pre_load (pre_g),
         .pre_val  (pin_in[i]),
         .set      (sync_set),
         .d        (sum_term[i]),
         .q        (q)
      );

      omc_outsel u_sel (
         .mode    (mode_cfg[OMC_MODE_W*i +: OMC_MODE_W]),
         .sum     (sum_term[i]),
         .q       (q),
         .oe_term (oe_term[i]),
         .preload (pre_g),
         .pin_in  (pin_in[i]),
         .pin_out (pin_out[i]),
         .pin_oe  (pin_oe[i]),
         .fb      (array_fb[i])
      );
   end
endmodule

// File: rtl/omc_bank_chk.sv
module omc_bank_chk #(
   parameter int NCELL       = 10,
   parameter bit HAS_PRELOAD = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NCELL-1:0]     sum_term,
   input logic [NCELL-1:0]     oe_term,
   input logic [2*NCELL-1:0]   mode_cfg,
   input logic                 sync_set,
   input logic                 async_clr,
   input logic                 preload,
   input logic [NCELL-1:0]     pin_in,
   input logic [NCELL-1:0]     pin_out,
   input logic [NCELL-1:0]     pin_oe,
   input logic [NCELL-1:0]     array_fb
);
   logic [NCELL-1:0] regmask;
   logic [NCELL-1:0] himask;
   logic [NCELL-1:0] resolved;
   logic             pre_on;

   always_comb begin
      for (int i = 0; i < NCELL; i++) begin
         regmask[i] = ~mode_cfg[2*i+1];
         himask[i]  = mode_cfg[2*i];
      end
      resolved = (pin_oe & pin_out) | (~pin_oe & pin_in);
      pre_on   = preload & HAS_PRELOAD;
   end

   // R1: power-up clear holds every register at 0
   a_r1_reset_clear: assert property (@(posedge clk) disable iff (async_clr)
      !rst_n |-> ((array_fb & regmask) == '0));

   // R2: asynchronous clear forces registers to 0
   a_r2_async_clear: assert property (@(posedge clk) disable iff (!rst_n)
      async_clr |-> ((array_fb & regmask) == '0));

   // R3: synchronous set loads 1 on the next edge
   a_r3_sync_set: assert property (@(posedge clk) disable iff (!rst_n || async_clr)
      (sync_set && !pre_on) |=>
         ((mode_cfg != $past(mode_cfg)) || ((array_fb & regmask) == regmask)));

   // R4: plain capture of the OR term
   a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n || async_clr)
      (!sync_set && !pre_on) |=>
         ((mode_cfg != $past(mode_cfg)) || (((array_fb ^ $past(sum_term)) & regmask) == '0)));

   // R5: registered cells drive state, inverted when active low
   a_r5_polarity: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_out ^ array_fb) & regmask) == (~himask & regmask));

   // R6: combinational cells follow the OR term
   a_r6_comb: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_out ^ sum_term) & ~regmask) == (~himask & ~regmask));

   // R7: enables released during preload, else follow the term
   a_r7_enable: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe == (pre_on ? '0 : oe_term));

   // R8: combinational cells feed back the resolved pin level
   a_r8_pin_fb: assert property (@(posedge clk) disable iff (!rst_n)
      ((array_fb ^ resolved) & ~regmask) == '0);

   // R9: preload writes the external pin level
   a_r9_preload: assert property (@(posedge clk) disable iff (!rst_n || async_clr)
      pre_on |=>
         ((mode_cfg != $past(mode_cfg)) || (((array_fb ^ $past(pin_in)) & regmask) == '0)));
endmodule

bind omc_bank omc_bank_chk #(.NCELL(NCELL), .HAS_PRELOAD(HAS_PRELOAD)) u_chk (.*);

// File: tb/omc_bank_test.sv
`timescale 1ns/1ps
module omc_bank_test;
   localparam int N = 10;
   localparam time TCLK = 20ns;

   typedef struct {
      logic [N-1:0] po;
      logic [N-1:0] oe;
      logic [N-1:0] fb;
      string        req;
   } exp_t;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N-1:0]   sum_term = '0;
   logic [N-1:0]   oe_term = '1;
   logic [2*N-1:0] mode_cfg = '0;
   logic           sync_set = 1'b0;
   logic           async_clr = 1'b0;
   logic           preload = 1'b0;
   logic [N-1:0]   pin_in = '0;
   logic [N-1:0]   pin_out, pin_oe, array_fb;

   int checks = 0;
   int failures = 0;
   bit done = 0;
   logic [N-1:0] mq = '0;   // model register state
   exp_t sb[$];

   always #(TCLK/2) clk = ~clk;

   omc_bank #(.NCELL(N)) uut (
      .clk(clk), .rst_n(rst_n), .sum_term(sum_term), .oe_term(oe_term),
      .mode_cfg(mode_cfg), .sync_set(sync_set), .async_clr(async_clr),
      .preload(preload), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .array_fb(array_fb)
   );

   function automatic exp_t model_out(input logic [N-1:0] q, input string req);
      exp_t e;
      for (int i = 0; i < N; i++) begin
         logic v, po, oe;
         v  = mode_cfg[2*i+1] ? sum_term[i] : q[i];
         po = mode_cfg[2*i] ? v : ~v;
         oe = oe_term[i] & ~preload;
         e.po[i] = po;
         e.oe[i] = oe;
         e.fb[i] = mode_cfg[2*i+1] ? (oe ? po : pin_in[i]) : q[i];
      end
      e.req = req;
      return e;
   endfunction

   function automatic logic [2*N-1:0] all_mode(input logic [1:0] m);
      logic [2*N-1:0] r;
      for (int i = 0; i < N; i++) r[2*i +: 2] = m;
      return r;
   endfunction

   task automatic compare(input exp_t e);
      checks++;
      if (pin_out !== e.po || pin_oe !== e.oe || array_fb !== e.fb) begin
         failures++;
         $display("FAIL %s: out=%h oe=%h fb=%h expected out=%h oe=%h fb=%h",
                  e.req, pin_out, pin_oe, array_fb, e.po, e.oe, e.fb);
      end
   endtask

   // driver: apply inputs on a falling edge, predict state after the next rising edge
   task automatic cyc(input logic [N-1:0] s, input logic [N-1:0] oe,
                      input logic [2*N-1:0] m, input logic ss, input logic ar,
                      input logic pre, input logic [N-1:0] pin, input string req);
      @(negedge clk);
      sum_term = s; oe_term = oe; mode_cfg = m; sync_set = ss;
      async_clr = ar; preload = pre; pin_in = pin;
      if (ar || !rst_n) mq = '0;
      else if (pre)     mq = pin;
      else if (ss)      mq = '1;
      else              mq = s;
      sb.push_back(model_out(mq, req));
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         #(TCLK/4);
         if (sb.size() > 0) compare(sb.pop_front());
      end
   end

   task automatic direct(input string req);
      compare(model_out(mq, req));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(TCLK * 200000);
      failures++;
      $display("FAIL watchdog: expired, expected completion");
      finish_run();
   end

   initial begin
      logic [2*N-1:0] mixed;
      for (int i = 0; i < N; i++) mixed[2*i +: 2] = 2'(i % 4);

      // R1: reset state seen through both polarities
      #(TCLK*2 + 3ns);
      direct("R1 reset active-low");
      mode_cfg = all_mode(2'b01);
      #1ns;
      direct("R1 reset active-high");
      cyc('1, '1, all_mode(2'b00), 1'b0, 1'b0, 1'b0, '0, "R1 reset holds");
      @(negedge clk);
      rst_n = 1'b1;

      // R4 capture, R5 polarity
      cyc(10'h2A5, '1, all_mode(2'b01), 0, 0, 0, '0, "R4 capture hi");
      cyc(10'h15A, '1, all_mode(2'b01), 0, 0, 0, '0, "R4 capture hi 2");
      cyc(10'h0F3, '1, all_mode(2'b00), 0, 0, 0, '0, "R5 active-low");
      // R6 combinational paths
      cyc(10'h155, '1, all_mode(2'b11), 0, 0, 0, '0, "R6 comb hi");
      cyc(10'h0C9, '1, all_mode(2'b10), 0, 0, 0, '0, "R6 comb lo");
      // R5/R6 mixed mode codes per cell
      cyc(10'h3A1, '1, mixed, 0, 0, 0, '0, "R5 R6 mixed");
      // R7 enables, R8 pin feedback with released drivers
      cyc(10'h26D, 10'h0F0, all_mode(2'b11), 0, 0, 0, 10'h30A, "R7 R8 comb fb");
      cyc(10'h1B4, 10'h33C, mixed, 0, 0, 0, 10'h2E7, "R8 mixed fb");
      // R3 synchronous set
      cyc('0, '1, all_mode(2'b00), 1, 0, 0, '0, "R3 sync set");
      // R2 clear and set together: immediate then after the edge
      cyc('1, '1, all_mode(2'b01), 1, 1, 0, '0, "R2 clear beats set");
      #2ns;
      direct("R2 immediate clear");
      cyc(10'h0AA, '1, all_mode(2'b01), 0, 0, 0, '0, "R4 after clear");
      // R9 preload with set: pin value wins, drivers released
      cyc('0, '1, all_mode(2'b01), 1, 0, 1, 10'h36C, "R9 preload beats set");
      cyc(10'h36C, '1, all_mode(2'b00), 0, 0, 0, '0, "R9 after preload");
      cyc('0, '1, all_mode(2'b01), 0, 1, 1, 10'h3FF, "R2 clear beats preload");
      cyc(10'h249, 10'h155, mixed, 0, 0, 0, 10'h0F0, "R4 R7 final");
      @(negedge clk);
      @(negedge clk);
      finish_run();
   end
endmodule